// File: doc/BRIEF.md
# Acquisition Channel Mask Normalizer

This block turns a requested channel selection into a set of channels that the acquisition path can actually use. Two converters sample channels in pairs, so a multi-channel set must have an even size. Every fixed-size packet body must also carry the same whole number of samples for each channel. A request that breaks either rule is widened by switching on extra channels, and the widened mask and its channel count are then reported.

The host side loads a raw 16-bit request and a resolution code, then pulses `start`. A small sequential engine latches the request and counts it. It then adds the lowest free channel, one per cycle, until the set is legal. The result is presented with a one-cycle `valid` pulse and stays on the outputs until the next accepted start.

Top module: `mask_normalizer`

## Requirements
- R1: Bit 0 of `req_mask` selects channel 1, up to bit 9 for channel 10. Bits 15..10 have no effect on the result.
- R2: A request with exactly one selected channel is returned unchanged, with a count of 1, at every resolution.
- R3: A request with an odd count greater than one gains one more channel, so that the count becomes even.
- R4: `res_code` encodes the sample width as 0 = 2 bits, 1 = 4 bits, 2 = 8 bits and 3 = 12 bits. For a count above one, the sample width times the count divides 480. Six channels at 12 bits grow to 8, and eight channels at 8 bits grow to 10.
- R5: Every added channel is the lowest-numbered channel that is not yet selected, searched upward from channel 1. Requested channels are never removed.
- R6: An empty request, including one with only bits 15..10 set, gives an empty mask and a count of 0, and `valid` is still pulsed.
- R7: `valid` is high for exactly one cycle, no more than 12 clock cycles after the cycle in which `start` is sampled.
- R8: `chan_count` equals the number of set bits in `eff_mask` whenever `valid` is high.
- R9: A `start` that arrives while a request is being processed is ignored. A `start` in the cycle that `valid` is high is accepted.
- R10: After reset, `valid` is low, `eff_mask` is 0 and `chan_count` is 0.
- R11: A request that already has an even count and divides the packet body evenly is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to normalize the current inputs |
| req_mask | input | 16 | Requested channel selection |
| res_code | input | 2 | Sample resolution code |
| eff_mask | output | 10 | Effective channel selection |
| chan_count | output | 4 | Number of channels in `eff_mask` |
| valid | output | 1 | One-cycle pulse marking a finished result |

## Verification
The parity fix and the packet-width fix can both act on a single request. Five channels at 12 bits first grow to six, which no longer divides the body, and then to eight. The bench drives such requests and compares the final mask against a hand-computed value, which shows that the two fixes are applied in order without skipping a channel. A second collision is between a new `start` and a finishing job. The bench raises `start` while the engine is busy and expects the first result, then raises it in the `valid` cycle and expects the new request to be accepted.

// File: rtl/mask_norm_pkg.sv
package mask_norm_pkg;

    typedef enum logic [1:0] {
        RES_2B  = 2'd0,
        RES_4B  = 2'd1,
        RES_8B  = 2'd2,
        RES_12B = 2'd3
    } res_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } st_e;

    function automatic int sample_bits(input res_e r);
        case (r)
            RES_2B:  return 2;
            RES_4B:  return 4;
            RES_8B:  return 8;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/mn_popcount.sv
module mn_popcount #(
    parameter int W  = 10,
    parameter int CW = 4
) (
    input  logic [W-1:0]  bits_in,
    output logic [CW-1:0] ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(bits_in[i]);
        end
    end
endmodule

// File: rtl/mn_lowest_free.sv
module mn_lowest_free #(
    parameter int W = 10
) (
    input  logic [W-1:0] taken,
    output logic [W-1:0] pick,
    output logic         none_free
);
    logic [W:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_chain
        assign pick[i]     = ~taken[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | ~taken[i];
    end

    assign none_free = ~seen[W];
endmodule

// File: rtl/mn_fit_check.sv
module mn_fit_check
    import mask_norm_pkg::*;
#(
    parameter int CW        = 4,
    parameter int BODY_BITS = 480
) (
    input  logic [CW-1:0] count,
    input  res_e          res,
    output logic          fits
);
    int prod;

    always_comb begin
        prod = sample_bits(res) * int'(count);
        if (count <= CW'(1)) begin
            fits = 1'b1;
        end else begin
            fits = !count[0] && ((BODY_BITS % prod) == 0);
        end
    end
endmodule

// File: rtl/mask_normalizer.sv
module mask_normalizer
    import mask_norm_pkg::*;
#(
    parameter int NCH       = 10,
    parameter int REQ_W     = 16,
    parameter int BODY_BITS = 480,
    localparam int CW       = $clog2(NCH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REQ_W-1:0] req_mask,
    input  logic [1:0]       res_code,
    output logic [NCH-1:0]   eff_mask,
    output logic [CW-1:0]    chan_count,
    output logic             valid
);

    typedef struct packed {
        st_e            st;
        logic [NCH-1:0] mask;
        logic [CW-1:0]  count;
        res_e           res;
        logic           valid;
    } regs_t;

    regs_t q, d;

    logic [CW-1:0]  req_ones;
    logic [NCH-1:0] pick;
    logic           none_free;
    logic           fits;

    mn_popcount #(.W(NCH), .CW(CW)) u_count (
        .bits_in (req_mask[NCH-1:0]),
        .ones    (req_ones)
    );

    mn_lowest_free #(.W(NCH)) u_free (
        .taken     (q.mask),
        .pick      (pick),
        .none_free (none_free)
    );

    mn_fit_check #(.CW(CW), .BODY_BITS(BODY_BITS)) u_fit (
        .count (q.count),
        .res   (q.res),
        .fits  (fits)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.mask  = req_mask[NCH-1:0];
                    d.count = req_ones;
                    d.res   = res_e'(res_code);
                    d.st    = ST_SCAN;
                end
            end
            default: begin
                if (fits || none_free) begin
                    d.valid = 1'b1;
                    d.st    = ST_IDLE;
                end else begin
                    d.mask  = q.mask | pick;
                    d.count = q.count + CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, mask: '0, count: '0, res: RES_2B, valid: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign eff_mask   = q.mask;
    assign chan_count = q.count;
    assign valid      = q.valid;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid); // R7

    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> ($countones(q.mask) == int'(q.count))); // R8

    AST_EVEN_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && q.count > CW'(1)) |-> !q.count[0]); // R3

    AST_BODY_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && q.count > CW'(1)) |->
            ((BODY_BITS % (sample_bits(q.res) * int'(q.count))) == 0)); // R4

    AST_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SCAN) |=> ((q.mask & $past(q.mask)) == $past(q.mask))); // R5

    AST_ONE_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SCAN && !fits && !none_free) |=>
            ($countones(q.mask) == $countones($past(q.mask)) + 1)); // R5

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SCAN && start) |=> $stable(q.res)); // R9

endmodule

// File: tb/mask_normalizer_test.sv
module mask_normalizer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 16;
    localparam int MAX_LAT    = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] req_mask = '0;
    logic [1:0]  res_code = '0;
    logic [9:0]  eff_mask;
    logic [3:0]  chan_count;
    logic        valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // {req_mask, res_code, expected mask, expected count}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h0003, 2'd3, 10'h003, 4'd2},   // R11
        {16'h0001, 2'd3, 10'h001, 4'd1},   // R2
        {16'h0007, 2'd0, 10'h00F, 4'd4},   // R3
        {16'h0015, 2'd1, 10'h017, 4'd4},   // R3 R5
        {16'h003F, 2'd3, 10'h0FF, 4'd8},   // R4
        {16'h00FF, 2'd2, 10'h3FF, 4'd10},  // R4
        {16'h00FF, 2'd3, 10'h0FF, 4'd8},   // R11
        {16'h003F, 2'd2, 10'h03F, 4'd6},   // R11
        {16'hFC00, 2'd3, 10'h000, 4'd0},   // R1 R6
        {16'hFC01, 2'd2, 10'h001, 4'd1},   // R1 R2
        {16'h0000, 2'd0, 10'h000, 4'd0},   // R6
        {16'h0155, 2'd3, 10'h17F, 4'd8},   // R3 R4 R5
        {16'h02A8, 2'd2, 10'h2A8, 4'd4},   // R11
        {16'h0380, 2'd2, 10'h381, 4'd4},   // R5
        {16'h01FE, 2'd2, 10'h3FF, 4'd10},  // R4 R5
        {16'h0200, 2'd0, 10'h200, 4'd1}    // R2
    };

    mask_normalizer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_mask   (req_mask),
        .res_code   (res_code),
        .eff_mask   (eff_mask),
        .chan_count (chan_count),
        .valid      (valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Pulses start for one cycle, then waits for valid; returns cycles waited.
    task automatic run_req(input logic [15:0] r, input logic [1:0] c, output int lat);
        @(negedge clk);
        req_mask = r;
        res_code = c;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat   = 1;
        while (!valid && lat <= MAX_LAT + 2) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(valid == 1'b0, "R10 valid", int'(valid), 0);
        check(eff_mask == '0, "R10 mask", int'(eff_mask), 0);
        check(chan_count == '0, "R10 count", int'(chan_count), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            run_req(VEC[i][31:16], VEC[i][15:14], lat);
            check(lat <= MAX_LAT, "R7 latency", lat, MAX_LAT);
            check(eff_mask == VEC[i][13:4], "R1-5/R11 mask", int'(eff_mask), int'(VEC[i][13:4]));
            check(chan_count == VEC[i][3:0], "R4/R6 count", int'(chan_count), int'(VEC[i][3:0]));
            check($countones(eff_mask) == int'(chan_count), "R8 popcount",
                  int'(chan_count), $countones(eff_mask));
            @(negedge clk);
            // R7: pulse lasts one cycle
            check(valid == 1'b0, "R7 pulse width", int'(valid), 0);
        end

        // R9: start while busy is ignored
        @(negedge clk);
        req_mask = 16'h0155; res_code = 2'd3; start = 1'b1;
        @(negedge clk);
        req_mask = 16'h0003; res_code = 2'd0;
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!valid && lat <= MAX_LAT + 2) begin
            @(negedge clk);
            lat++;
        end
        check(eff_mask == 10'h17F, "R9 busy start ignored", int'(eff_mask), 'h17F);
        // R9: start in the valid cycle is accepted
        req_mask = 16'h0007; res_code = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!valid && lat <= MAX_LAT + 2) begin
            @(negedge clk);
            lat++;
        end
        check(valid == 1'b1, "R9 back-to-back valid", int'(valid), 1);
        check(eff_mask == 10'h00F, "R9 back-to-back mask", int'(eff_mask), 'h00F);
        check(chan_count == 4'd4, "R9 back-to-back count", int'(chan_count), 4);

        // R7: no spurious second pulse while idle
        lat = 0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (valid) lat++;
        end
        check(lat == 0, "R7 no extra pulse", lat, 0);

        // R10: reset mid-operation clears outputs
        @(negedge clk);
        req_mask = 16'h01FE; res_code = 2'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(eff_mask == '0 && chan_count == '0 && !valid, "R10 reset clears",
              int'(eff_mask), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule